// File: doc/BRIEF.md
# Oscillator Offset Trimmer

The block divides a stream of low-frequency oscillator pulses into one-second periods and corrects the rate of the resulting seconds for crystal error. At a fixed correction interval it shortens or lengthens one second by an even number of oscillator pulses. Each request adds or removes a pair of pulses. The interval is either 20 s (coarse, about 3051 ppb per step) or 60 s (fine, about 1017 ppb per step).

Software writes one 8-bit correction word. The write lands in a staging register and raises a busy flag. At the next end of second the staged word moves into the active register and the flag drops. A write made while the flag is up is discarded. The end of each second is reported by a one-cycle pulse, which is what the calendar advances on.

Top module: `osc_trim`

## Requirements
- R1: While and after reset, busy_o is 0, sec_tick_o is 0 until the first second completes, the active correction word is 0, and the second counter starts at index 0.
- R2: A second that carries no correction lasts exactly PULSES_PER_SEC cycles with tick_i high. sec_tick_o is high for exactly one cycle, the cycle after the edge that consumed the last pulse.
- R3: Seconds are indexed from 0 after reset. With word bit 7 = 1 only seconds whose index is a multiple of 60 are corrected. With bit 7 = 0, seconds whose index is a multiple of 20 are corrected.
- R4: With bit 6 = 0 (add), the step count is field[5:0] − 1. A corrected second is shorter by 2 × steps pulses.
- R5: With bit 6 = 1 (subtract), the step count is (bitwise NOT of field[5:0], 6 bits) + 1. A corrected second is longer by 2 × steps pulses.
- R6: A field value of 0 gives no correction in either direction. An add word with field 1 also gives zero steps.
- R7: The step count never exceeds 62. Add field 63 gives 62 steps. Subtract field 1 decodes to 63 and is clamped to 62.
- R8: A write with busy_o low sets busy_o high in the next cycle. At the next end of second the word becomes active for the second that starts there, and busy_o returns low at that same edge.
- R9: A write made while busy_o is high is ignored. The staged word is unchanged, and the seconds that follow use the earlier word.
- R10: Only cycles with tick_i high advance the second. Gaps in tick_i stretch time without changing the pulse count of any second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One oscillator pulse, one-cycle enable |
| wr_en_i | input | 1 | Correction word write strobe |
| wr_data_i | input | 8 | Correction word: [7] 60 s interval, [6] subtract, [5:0] magnitude |
| busy_o | output | 1 | Staged word not yet transferred |
| sec_tick_o | output | 1 | One-cycle pulse at end of each second |

## Verification
A wrong decode or a wrong interval phase shows up only as a wrong pulse count on one second in every 20 or 60. The bench therefore measures every second between sec_tick_o pulses against a model of the active word and the second index. A fault is reported at the end of the first corrected second, which comes at most one full interval after the word transfers. A fault in the staging path shows within one second, either as busy_o holding the wrong value or as a correction taking effect one second early or late.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  localparam int MAG_W    = 6;
  localparam int STEP_MAX = 62;

  typedef struct packed {
    logic             long_iv;  // 60 s interval when set
    logic             sub;      // lengthen second when set
    logic [MAG_W-1:0] mag;
  } trim_cfg_t;
endpackage

// File: rtl/trim_decode.sv
module trim_decode
  import osc_trim_pkg::*;
(
  input  trim_cfg_t        cfg_i,
  output logic [MAG_W-1:0] steps_o
);
  logic [MAG_W:0] raw;

  always_comb begin
    if (cfg_i.mag == '0)
      raw = '0;
    else if (cfg_i.sub)
      raw = {1'b0, ~cfg_i.mag} + (MAG_W+1)'(1);
    else
      raw = {1'b0, cfg_i.mag} - (MAG_W+1)'(1);
    if (raw > (MAG_W+1)'(STEP_MAX))
      raw = (MAG_W+1)'(STEP_MAX);
  end

  assign steps_o = raw[MAG_W-1:0];
endmodule

// File: rtl/trim_sched.sv
module trim_sched #(
  parameter int SHORT_IV = 20,
  parameter int LONG_IV  = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_end_i,
  input  logic long_iv_i,
  output logic corr_o
);
  localparam int GRP  = LONG_IV / SHORT_IV;
  localparam int SH_W = (SHORT_IV > 1) ? $clog2(SHORT_IV) : 1;
  localparam int GR_W = (GRP > 1) ? $clog2(GRP) : 1;

  logic [SH_W-1:0] sh_cnt_q;
  logic [GR_W-1:0] grp_cnt_q;
  logic            sh_wrap;

  assign sh_wrap = (sh_cnt_q == SH_W'(SHORT_IV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_cnt_q <= '0;
    end else if (sec_end_i) begin
      sh_cnt_q <= sh_wrap ? '0 : sh_cnt_q + SH_W'(1);
    end
  end

  generate
    if (GRP > 1) begin : g_grp
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          grp_cnt_q <= '0;
        else if (sec_end_i && sh_wrap)
          grp_cnt_q <= (grp_cnt_q == GR_W'(GRP - 1)) ? '0 : grp_cnt_q + GR_W'(1);
      end
    end else begin : g_nogrp
      assign grp_cnt_q = '0;
    end
  endgenerate

  assign corr_o = (sh_cnt_q == '0) && (!long_iv_i || grp_cnt_q == '0);
endmodule

// File: rtl/trim_prescale.sv
module trim_prescale
  import osc_trim_pkg::*;
#(
  parameter int PULSES_PER_SEC = 32768,
  parameter int CNT_W          = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             corr_i,
  input  logic             sub_i,
  input  logic [MAG_W-1:0] steps_i,
  output logic             sec_end_o,
  output logic             sec_tick_o
);
  localparam logic [CNT_W-1:0] BASE = CNT_W'(PULSES_PER_SEC);

  logic [CNT_W-1:0] cnt_q, adj, len, last;

  assign adj  = CNT_W'({steps_i, 1'b0});
  assign len  = !corr_i ? BASE : (sub_i ? BASE + adj : BASE - adj);
  assign last = len - CNT_W'(1);
  assign sec_end_o = tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sec_tick_o <= 1'b0;
    end else begin
      sec_tick_o <= sec_end_o;
      if (sec_end_o)
        cnt_q <= '0;
      else if (tick_i)
        cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/osc_trim.sv
module osc_trim
  import osc_trim_pkg::*;
#(
  parameter int PULSES_PER_SEC = 32768,
  parameter int SHORT_IV       = 20,
  parameter int LONG_IV        = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic       busy_o,
  output logic       sec_tick_o
);
  localparam int CNT_W = $clog2(PULSES_PER_SEC + 2 * STEP_MAX + 1);

  trim_cfg_t        pending_q, active_q;
  logic             busy_q, sec_end, corr;
  logic [MAG_W-1:0] steps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= '0;
      active_q  <= '0;
      busy_q    <= 1'b0;
    end else begin
      if (sec_end && busy_q) begin
        active_q <= pending_q;
        busy_q   <= 1'b0;
      end
      // accepted only while idle; same-edge idle write stays staged
      if (wr_en_i && !busy_q) begin
        pending_q <= trim_cfg_t'(wr_data_i);
        busy_q    <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;

  trim_decode u_dec (
    .cfg_i   (active_q),
    .steps_o (steps)
  );

  trim_sched #(
    .SHORT_IV (SHORT_IV),
    .LONG_IV  (LONG_IV)
  ) u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_end_i (sec_end),
    .long_iv_i (active_q.long_iv),
    .corr_o    (corr)
  );

  trim_prescale #(
    .PULSES_PER_SEC (PULSES_PER_SEC),
    .CNT_W          (CNT_W)
  ) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .corr_i     (corr),
    .sub_i      (active_q.sub),
    .steps_i    (steps),
    .sec_end_o  (sec_end),
    .sec_tick_o (sec_tick_o)
  );
endmodule

// File: rtl/osc_trim_chk.sv
module osc_trim_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       busy_o,
  input logic       sec_tick_o,
  input logic [7:0] pending_i,
  input logic [7:0] active_i,
  input logic [5:0] steps_i
);
  assert_busy_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_en_i));

  assert_busy_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> sec_tick_o);

  assert_active_update_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_i) |-> sec_tick_o);

  assert_ignored_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i) |=> $stable(pending_i));

  assert_tick_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);

  assert_step_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steps_i <= 6'd62);
endmodule

bind osc_trim osc_trim_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .busy_o     (busy_o),
  .sec_tick_o (sec_tick_o),
  .pending_i  (pending_q),
  .active_i   (active_q),
  .steps_i    (steps)
);

// File: tb/tb_osc_trim.sv
module tb_osc_trim;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 256;
  localparam int WD_LIMIT   = 190000;

  typedef struct packed {
    logic [7:0] code;
    logic [7:0] secs;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'h05, 8'd21},  // R4: add, 4 steps, 20 s
    '{8'h45, 8'd21},  // R5: sub, 59 steps, 20 s
    '{8'hBF, 8'd61},  // R7: add field 63 -> 62 steps, 60 s
    '{8'hC1, 8'd61},  // R7: sub field 1 -> clamp 62, 60 s
    '{8'h01, 8'd21},  // R6: add field 1 -> 0 steps
    '{8'h7F, 8'd21},  // R5: sub field 63 -> 1 step
    '{8'h40, 8'd21}   // R6: sub field 0 -> none
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       busy_o, sec_tick_o;

  int    n_chk = 0, n_fail = 0;
  logic [7:0] m_active = '0, m_pending = '0;
  bit    m_busy = 1'b0;
  int    gap_mode = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_trim #(.PULSES_PER_SEC(BASE)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .busy_o     (busy_o),
    .sec_tick_o (sec_tick_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  function automatic int steps_of(logic [7:0] c);
    int m = int'(c[5:0]);
    int s;
    if (m == 0)      s = 0;
    else if (c[6])   s = ((~m) & 63) + 1;
    else             s = m - 1;
    if (s > 62) s = 62;
    return s;
  endfunction

  function automatic bit corr_at(logic [7:0] c, int idx);
    return c[7] ? (idx % 60 == 0) : (idx % 20 == 0);
  endfunction

  function automatic int exp_len(logic [7:0] c, int idx);
    int s = steps_of(c);
    if (!corr_at(c, idx)) return BASE;
    return c[6] ? BASE + 2 * s : BASE - 2 * s;
  endfunction

  // monitor + tick source, all at negedge
  initial begin
    int cnt = 0, idx = 0, phase = 0;
    string tag;
    forever begin
      @(negedge clk);
      if (!rst_ni) begin
        tick_i = 1'b0; cnt = 0; idx = 0;
      end else begin
        if (sec_tick_o) begin
          if (!corr_at(m_active, idx))      tag = "R3";
          else if (steps_of(m_active) == 0) tag = "R6";
          else if (m_active[6])             tag = "R5";
          else                              tag = "R4";
          chk(cnt == exp_len(m_active, idx), {cur_req, "/", tag}, cnt, exp_len(m_active, idx));
          chk(busy_o == 1'b0, "R8 busy after tick", int'(busy_o), 0);
          if (m_busy) begin
            m_active = m_pending;
            m_busy   = 1'b0;
          end
          idx = (idx + 1) % 60;
          cnt = 0;
        end
        phase++;
        tick_i = (gap_mode == 0) ? 1'b1 : (phase % 3 != 2);
        if (tick_i) cnt++;
      end
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!sec_tick_o);
  endtask

  task automatic wait_secs(input int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic apply(input logic [7:0] code);
    wait_tick();
    @(negedge clk);
    chk(sec_tick_o == 1'b0, "R2 one-cycle tick", int'(sec_tick_o), 0);
    chk(busy_o == 1'b0, "R8 idle before write", int'(busy_o), 0);
    wr_en_i = 1'b1; wr_data_i = code;
    m_pending = code; m_busy = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after write", int'(busy_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy in reset", int'(busy_o), 0);
    chk(sec_tick_o == 1'b0, "R1 tick in reset", int'(sec_tick_o), 0);
    @(negedge clk);
    #1 rst_ni = 1'b1;
    cur_req = "R1";
    wait_secs(2);

    cur_req = "TBL";
    foreach (VECS[i]) begin
      apply(VECS[i].code);
      wait_secs(int'(VECS[i].secs) - 1);
    end

    // R9: second write while busy must be dropped
    cur_req = "R9";
    apply(8'h05);
    wr_en_i = 1'b1; wr_data_i = 8'h45;
    @(negedge clk);
    wr_en_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy held", int'(busy_o), 1);
    wait_secs(20);

    // R10: gaps in tick_i, same pulse counts expected
    cur_req = "R10";
    gap_mode = 1;
    apply(8'h48);
    wait_secs(20);
    gap_mode = 0;

    summary();
    $finish;
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WD_LIMIT) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog act=%0d exp<=%0d", cyc, WD_LIMIT);
        summary();
        $finish;
      end
    end
  end
endmodule